// File: doc/BRIEF.md
# Central Bus Arbiter with Three Selectable Priority Schemes

This block decides which of N masters may drive a shared bus next. A two-bit mode input picks one of three centralized schemes. In the chained scheme a single grant token enters at master 0 and stops at the first master that is requesting. In the polled scheme a counter walks an address over a poll bus, one address per clock, and the first requesting master whose address comes up takes the bus. In the independent scheme every master has its own request and grant pair, and the winner is chosen from a priority table that software loads through a small write port.

A new contest begins only while the bus is quiet (busy low) and at least one request is pending. The winner receives a one-hot grant and keeps it while it drives busy. When it drops busy, or when it withdraws its request before ever raising busy, the grant is released and the next contest may start.

Top module: `bus_arb_top`

## Requirements
- R1: After reset, grant_o is all zero, poll_active_o is low, poll_addr_o is 0 and the priority table holds slot k = master k (slot 0 is the highest priority).
- R2: At most one bit of grant_o is high in any cycle.
- R3: A contest starts only on a clock edge where busy_i is low and some request is set. In chained and independent modes the grant is visible one cycle after that edge. While busy_i stays high no new grant is issued.
- R4: A grant does not change while busy_i is high. It is cleared on the first edge where busy_i is low after the owner has raised busy_i, or on the first edge where the owner's request is low while busy_i has stayed low since the grant.
- R5: Mode 0 (chained): the requesting master with the lowest index wins.
- R6: Mode 0: a master at index 0 that requests again after each release keeps winning over a requesting master at index 3.
- R7: Mode 1 (polled): on the start edge the counter loads its start value, and poll_active_o goes high. Each later edge either grants the master at poll_addr_o, if it is requesting, or steps the address by one, wrapping N-1 to 0. With poll_resume_i = 0 the start value is 0, so the grant shows (winner - start) mod N + 2 cycles after the requests appear.
- R8: Mode 1 with poll_resume_i = 1: polling starts at the previous polled winner plus one, modulo N.
- R9: Mode 1: poll_active_o is never high while a grant is held. If every request drops during polling, the arbiter goes idle with no grant and poll_addr_o keeps its value.
- R10: Mode 2 (independent): the winner is the requesting master that appears in the lowest-numbered slot of the priority table.
- R11: A write (prio_we_i high, slot prio_slot_i, master prio_idx_i) puts that master into the slot and moves the slot's old master to the slot the written master left, so the table always stays a permutation. Writes with an index of N or more are ignored. A write takes effect for contests that start after the write edge.
- R12: Mode 3 is reserved: no contest starts in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Scheme: 0 chained, 1 polled, 2 independent, 3 reserved |
| poll_resume_i | input | 1 | Polled mode: 1 resumes after the last winner, 0 restarts at 0 |
| req_i | input | N | Per-master request lines |
| busy_i | input | 1 | Bus busy, driven by the current owner |
| grant_o | output | N | One-hot grant |
| poll_active_o | output | 1 | High while the poll counter is stepping |
| poll_addr_o | output | log2(N) | Address driven on the poll bus |
| prio_we_i | input | 1 | Priority table write strobe |
| prio_slot_i | input | log2(N) | Table slot to write (0 = highest) |
| prio_idx_i | input | log2(N) | Master index to place in the slot |

## Verification
On every cycle the assertions check that the grant is one-hot or empty, that it holds while busy, that a fresh grant follows a quiet bus and a live request, that a polled win goes to the address shown the cycle before, that no grant coexists with polling, that the priority table stays a permutation, and that mode 3 never grants. Only the bench scenarios can show which master wins under each scheme, the exact polling latency with and without resume, starvation in the chained mode, and the timing of a table write that lands on the same edge as a contest.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Scheme selector, value is the encoding of mode_i
  typedef enum logic [1:0] {
    ARB_CHAIN = 2'd0,
    ARB_POLL  = 2'd1,
    ARB_INDEP = 2'd2,
    ARB_OFF   = 2'd3
  } arb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;

endpackage

// File: rtl/bus_arb_chain.sv
// Token passes from index 0 upward and stops at the first requester.
module bus_arb_chain #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          win_valid_o,
  output logic [IW-1:0] win_idx_o
);

  logic [N:0]   pass;
  logic [N-1:0] take;

  assign pass[0] = 1'b1;

  for (genvar g = 0; g < N; g++) begin : g_link
    assign take[g]   = pass[g] & req_i[g];
    assign pass[g+1] = pass[g] & ~req_i[g];
  end

  assign win_valid_o = ~pass[N];

  always_comb begin
    win_idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (take[k]) win_idx_o = IW'(k);
    end
  end

endmodule

// File: rtl/bus_arb_poll.sv
// Poll address counter with restart or resume start point.
module bus_arb_poll #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          resume_i,
  input  logic          step_i,
  input  logic          won_i,
  output logic [IW-1:0] addr_o
);

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] last_q;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] v);
    if (v == IW'(N-1)) return '0;
    return v + IW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (start_i) cnt_q <= resume_i ? wrap_inc(last_q) : '0;
      else if (step_i) cnt_q <= wrap_inc(cnt_q);
      if (won_i) last_q <= cnt_q;
    end
  end

  assign addr_o = cnt_q;

endmodule

// File: rtl/bus_arb_prio.sv
// Programmable priority table (slot 0 highest) and winner pick.
module bus_arb_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] slot_i,
  input  logic [IW-1:0] idx_i,
  input  logic [N-1:0]  req_i,
  output logic          win_valid_o,
  output logic [IW-1:0] win_idx_o,
  output logic [N*IW-1:0] order_flat_o
);

  logic [IW-1:0] order_q [N];
  logic          wr_ok;

  assign wr_ok = we_i && (int'(slot_i) < N) && (int'(idx_i) < N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) order_q[k] <= IW'(k);
    end else if (wr_ok) begin
      for (int k = 0; k < N; k++) begin
        if (IW'(k) == slot_i) order_q[k] <= idx_i;
        else if (order_q[k] == idx_i) order_q[k] <= order_q[slot_i];
      end
    end
  end

  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int k = N-1; k >= 0; k--) begin
      if (req_i[order_q[k]]) begin
        win_valid_o = 1'b1;
        win_idx_o   = order_q[k];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign order_flat_o[g*IW +: IW] = order_q[g];
  end

endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
  import bus_arb_pkg::*;
#(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          poll_resume_i,
  input  logic [N-1:0]  req_i,
  input  logic          busy_i,
  output logic [N-1:0]  grant_o,
  output logic          poll_active_o,
  output logic [IW-1:0] poll_addr_o,
  input  logic          prio_we_i,
  input  logic [IW-1:0] prio_slot_i,
  input  logic [IW-1:0] prio_idx_i
);

  arb_mode_e  mode;
  arb_state_e state_q;
  logic [IW-1:0] owner_q;
  logic [N-1:0]  grant_q;
  logic          seen_busy_q;

  logic          chain_valid, prio_valid;
  logic [IW-1:0] chain_idx, prio_idx, sel_idx, poll_addr;
  logic [N*IW-1:0] order_flat;

  // named events
  logic any_req, arb_start, direct_win, poll_start, poll_hit, poll_step, poll_empty, release_evt;

  function automatic logic [N-1:0] to_onehot(input logic [IW-1:0] i);
    logic [N-1:0] v;
    v    = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  assign mode = arb_mode_e'(mode_i);

  bus_arb_chain #(.N(N), .IW(IW)) u_chain (
    .req_i(req_i), .win_valid_o(chain_valid), .win_idx_o(chain_idx)
  );

  bus_arb_prio #(.N(N), .IW(IW)) u_prio (
    .clk(clk), .rst_n(rst_n), .we_i(prio_we_i), .slot_i(prio_slot_i),
    .idx_i(prio_idx_i), .req_i(req_i), .win_valid_o(prio_valid),
    .win_idx_o(prio_idx), .order_flat_o(order_flat)
  );

  bus_arb_poll #(.N(N), .IW(IW)) u_poll (
    .clk(clk), .rst_n(rst_n), .start_i(poll_start), .resume_i(poll_resume_i),
    .step_i(poll_step), .won_i(poll_hit), .addr_o(poll_addr)
  );

  assign any_req    = |req_i;
  assign arb_start  = (state_q == ST_IDLE) && !busy_i && any_req && (mode != ARB_OFF);
  assign sel_idx    = (mode == ARB_CHAIN) ? chain_idx : prio_idx;
  assign direct_win = arb_start &&
                      (((mode == ARB_CHAIN) && chain_valid) || ((mode == ARB_INDEP) && prio_valid));
  assign poll_start = arb_start && (mode == ARB_POLL);
  assign poll_hit   = (state_q == ST_POLL) && req_i[poll_addr];
  assign poll_empty = (state_q == ST_POLL) && !any_req;
  assign poll_step  = (state_q == ST_POLL) && any_req && !req_i[poll_addr];
  assign release_evt = (state_q == ST_OWN) && !busy_i && (seen_busy_q || !req_i[owner_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      owner_q     <= '0;
      grant_q     <= '0;
      seen_busy_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (direct_win) begin
            state_q <= ST_OWN;
            owner_q <= sel_idx;
            grant_q <= to_onehot(sel_idx);
          end else if (poll_start) begin
            state_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (poll_hit) begin
            state_q <= ST_OWN;
            owner_q <= poll_addr;
            grant_q <= to_onehot(poll_addr);
          end else if (poll_empty) begin
            state_q <= ST_IDLE;
          end
        end
        ST_OWN: begin
          if (busy_i) seen_busy_q <= 1'b1;
          if (release_evt) begin
            state_q     <= ST_IDLE;
            grant_q     <= '0;
            seen_busy_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign grant_o       = grant_q;
  assign poll_active_o = (state_q == ST_POLL);
  assign poll_addr_o   = poll_addr;

endmodule

// File: rtl/bus_arb_checker.sv
module bus_arb_checker #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode_i,
  input logic [N-1:0]    req_i,
  input logic            busy_i,
  input logic [N-1:0]    grant_o,
  input logic            poll_active_o,
  input logic [IW-1:0]   poll_addr_o,
  input logic [N*IW-1:0] order_flat
);

  logic [N-1:0] present;
  logic [N-1:0] unit;

  assign unit = {{(N-1){1'b0}}, 1'b1};

  always_comb begin
    present = '0;
    for (int k = 0; k < N; k++) present[order_flat[k*IW +: IW]] = 1'b1;
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && busy_i) |=> $stable(grant_o));

  p_start_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && $past(grant_o) == '0) |-> (!$past(busy_i) && (($past(req_i) & grant_o) != '0)));

  p_poll_addr_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(poll_active_o) && grant_o != '0 && $past(grant_o) == '0) |-> (grant_o == (unit << $past(poll_addr_o))));

  p_poll_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    poll_active_o |-> (grant_o == '0));

  p_table_perm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    present == '1);

  p_reserved_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 2'd3 && $past(grant_o) == '0 && !$past(poll_active_o)) |-> (grant_o == '0));

endmodule

bind bus_arb_top bus_arb_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_i(req_i), .busy_i(busy_i),
  .grant_o(grant_o), .poll_active_o(poll_active_o), .poll_addr_o(poll_addr_o),
  .order_flat(order_flat)
);

// File: tb/tb_bus_arb_top.sv
module tb_bus_arb_top;

  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          poll_resume_i = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic          busy_i = 1'b0;
  logic [N-1:0]  grant_o;
  logic          poll_active_o;
  logic [IW-1:0] poll_addr_o;
  logic          prio_we_i = 1'b0;
  logic [IW-1:0] prio_slot_i = '0;
  logic [IW-1:0] prio_idx_i = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bus_arb_top #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .poll_resume_i(poll_resume_i),
    .req_i(req_i), .busy_i(busy_i), .grant_o(grant_o), .poll_active_o(poll_active_o),
    .poll_addr_o(poll_addr_o), .prio_we_i(prio_we_i), .prio_slot_i(prio_slot_i),
    .prio_idx_i(prio_idx_i)
  );

  // {mode[11:10], req[9:6], winner[5:4], latency[3:0]}
  localparam logic [11:0] VEC [10] = '{
    {2'd0, 4'b0110, 2'd1, 4'd1},
    {2'd0, 4'b1000, 2'd3, 4'd1},
    {2'd0, 4'b1111, 2'd0, 4'd1},
    {2'd2, 4'b1100, 2'd2, 4'd1},
    {2'd2, 4'b0101, 2'd0, 4'd1},
    {2'd2, 4'b1000, 2'd3, 4'd1},
    {2'd1, 4'b0100, 2'd2, 4'd4},
    {2'd1, 4'b0001, 2'd0, 4'd2},
    {2'd1, 4'b1010, 2'd1, 4'd3},
    {2'd1, 4'b1000, 2'd3, 4'd5}
  };

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_grant(output int lat);
    lat = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      lat++;
      if (grant_o != '0) break;
    end
  endtask

  // owner raises busy, drops request, then drops busy
  task automatic finish_own(input string tag);
    logic [N-1:0] held;
    held   = grant_o;
    busy_i = 1'b1;
    req_i  = '0;
    @(negedge clk);
    check(grant_o == held, tag, "grant held while busy", grant_o, held);
    busy_i = 1'b0;
    @(negedge clk);
    check(grant_o == '0, tag, "grant released after busy drop", grant_o, 0);
  endtask

  task automatic one_round(input logic [1:0] m, input logic res, input logic [N-1:0] r,
                           input int exp_idx, input int exp_lat, input string tag);
    int lat;
    mode_i = m;
    poll_resume_i = res;
    req_i = r;
    wait_grant(lat);
    check(grant_o == (4'b0001 << exp_idx), tag, "winner grant", grant_o, 1 << exp_idx);
    check(lat == exp_lat, tag, "grant latency", lat, exp_lat);
    finish_own(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(grant_o == '0, "R1", "grant after reset", grant_o, 0);
    check(poll_active_o == 1'b0, "R1", "poll_active after reset", poll_active_o, 0);
    check(poll_addr_o == '0, "R1", "poll_addr after reset", poll_addr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant_o == '0, "R1", "grant idle with no request", grant_o, 0);

    // vector walk: R5 chained, R10 independent with identity table (R1), R7 polled
    for (int v = 0; v < 10; v++) begin
      one_round(VEC[v][11:10], 1'b0, VEC[v][9:6], int'(VEC[v][5:4]), int'(VEC[v][3:0]),
                (VEC[v][11:10] == 2'd0) ? "R5" : (VEC[v][11:10] == 2'd2) ? "R10" : "R7");
    end

    // R7: poll address steps one per cycle from 0
    mode_i = 2'd1; poll_resume_i = 1'b0; req_i = 4'b1000;
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      check(poll_active_o && poll_addr_o == IW'(a), "R7", "poll address step", poll_addr_o, a);
    end
    @(negedge clk);
    check(grant_o == 4'b1000, "R7", "grant after walk", grant_o, 8);
    finish_own("R7");

    // R8: resume after last polled winner (3)
    one_round(2'd1, 1'b1, 4'b0011, 0, 2, "R8");
    one_round(2'd1, 1'b1, 4'b0011, 1, 2, "R8");
    one_round(2'd1, 1'b1, 4'b0001, 0, 4, "R8");

    // R9: requests vanish during polling
    mode_i = 2'd1; poll_resume_i = 1'b0; req_i = 4'b1000;
    @(negedge clk);
    check(poll_active_o == 1'b1, "R9", "polling started", poll_active_o, 1);
    req_i = '0;
    @(negedge clk);
    check(poll_active_o == 1'b0 && grant_o == '0, "R9", "idle after requests vanish", grant_o, 0);
    check(poll_addr_o == 2'd0, "R9", "poll address held", poll_addr_o, 0);
    repeat (2) @(negedge clk);
    check(poll_active_o == 1'b0, "R9", "counter idle without requests", poll_active_o, 0);

    // R6: chained starvation of index 3
    mode_i = 2'd0; req_i = 4'b1001;
    for (int r = 0; r < 3; r++) begin
      wait_grant(lat);
      check(grant_o == 4'b0001, "R6", "index 0 keeps winning", grant_o, 1);
      busy_i = 1'b1;
      @(negedge clk);
      busy_i = 1'b0;
    end
    wait_grant(lat);
    finish_own("R6");

    // R3: no contest while busy high
    mode_i = 2'd0; busy_i = 1'b1; req_i = 4'b0010;
    repeat (3) @(negedge clk);
    check(grant_o == '0, "R3", "no grant while busy", grant_o, 0);
    busy_i = 1'b0;
    wait_grant(lat);
    check(lat == 1 && grant_o == 4'b0010, "R3", "grant one cycle after quiet", lat, 1);
    finish_own("R3");

    // R4: withdraw request before raising busy
    req_i = 4'b0100;
    wait_grant(lat);
    req_i = '0;
    @(negedge clk);
    check(grant_o == '0, "R4", "release on withdrawn request", grant_o, 0);

    // R11: swap writes, table [0,1,2,3] -> [3,1,2,0]
    prio_we_i = 1'b1; prio_slot_i = 2'd0; prio_idx_i = 2'd3;
    @(negedge clk);
    prio_we_i = 1'b0;
    one_round(2'd2, 1'b0, 4'b1111, 3, 1, "R11");
    one_round(2'd2, 1'b0, 4'b0101, 2, 1, "R11");
    // [3,1,2,0] -> [3,0,2,1]
    prio_we_i = 1'b1; prio_slot_i = 2'd1; prio_idx_i = 2'd0;
    @(negedge clk);
    prio_we_i = 1'b0;
    one_round(2'd2, 1'b0, 4'b0111, 0, 1, "R11");
    one_round(2'd2, 1'b0, 4'b0110, 2, 1, "R11");
    // write on same edge as contest: old table [3,0,2,1] decides, new is [1,0,2,3]
    mode_i = 2'd2; req_i = 4'b0011;
    prio_we_i = 1'b1; prio_slot_i = 2'd0; prio_idx_i = 2'd1;
    @(negedge clk);
    prio_we_i = 1'b0;
    check(grant_o == 4'b0001, "R11", "same-edge write uses old order", grant_o, 1);
    finish_own("R11");
    one_round(2'd2, 1'b0, 4'b0011, 1, 1, "R11");

    // R12: reserved mode
    mode_i = 2'd3; req_i = 4'b1111;
    repeat (4) @(negedge clk);
    check(grant_o == '0 && poll_active_o == 1'b0, "R12", "reserved mode no grant", grant_o, 0);
    req_i = '0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule